// File: doc/BRIEF.md
# Auto-Reload 16-bit Down Timer

This block is a periodic interval timer for a small 8-bit controller. Software loads a 16-bit reload value through two byte-wide, write-only registers, sets a run bit, and then receives an interrupt request at a fixed rate. While running, the counter steps down by one on each tick from the selected tick input. When it steps past zero it wraps, takes the reload value in place of FFFFh, and latches a pending flag. With a reload value of N, interrupts arrive every N+1 ticks.

The counter comes out of reset at zero. The first tick after the timer is switched on therefore produces an interrupt at once and loads the reload value. Software should write the reload value before it sets the run bit. A 2-bit clock-mode input selects which synchronous tick pulse feeds the counter. The interrupt line is the pending flag gated by an interrupt-enable bit. Software clears the pending flag with a separate strobe.

Top module: `tmr16_top`

## Requirements
- R1: After reset the counter is 0000h, the run bit and the interrupt-enable bit are 0, no interrupt is pending and `irq` is low.
- R2: While the run bit is 1, each selected tick lowers a nonzero count by exactly one and raises no interrupt.
- R3: A selected tick while the count is 0000h is an underflow. The counter loads the reload value instead of FFFFh, and the pending flag is set.
- R4: With reload value N, consecutive underflows are N+1 selected ticks apart. The reload high byte counts as bits 15:8.
- R5: If the timer is first enabled with the reset count of zero, the first selected tick raises the interrupt and loads the reload value.
- R6: Address 0x03 holds reload bits 7:0 and address 0x04 holds bits 15:8. Both are write-only and read as 0x00. Writing them does not change the running count; the new value is used at the next underflow.
- R7: Bit 2 of address 0x09 is the run bit and bit 2 of address 0x02 is the interrupt-enable bit. Both can be read and written. Their other bits, and any unmapped address, read as 0.
- R8: `irq` is the pending flag AND the interrupt-enable bit. The pending flag stays set until an `irq_clear` pulse. If an underflow and a clear happen in the same cycle, the flag stays set.
- R9: The tick source follows `clk_mode`: 00 (dual clock) and 01 (slow only) use `slow_tick`, 10 (fast only) uses `fast_tick`, and 11 selects no tick.
- R10: While the run bit is 0 the count holds and no underflow occurs, whatever the tick inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| clk_mode | input | 2 | System clock mode, selects the tick source |
| slow_tick | input | 1 | Single-cycle tick from the slow clock domain |
| fast_tick | input | 1 | Single-cycle tick from the fast clock domain |
| irq_clear | input | 1 | Clears the pending interrupt flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after the first tick after reset. A design that tested for reaching zero instead of wrapping past it would stay silent there, or would interrupt one tick early in every later period, so the N+1 spacing check would catch it. It rewrites the reload bytes in the middle of a period; a design that copied them straight into the counter would shorten that period. It also drives the tick that is not selected in each clock mode, and ticks with the timer stopped; a design with a wrong source mux or a free-running counter would then give an interrupt at the wrong time. It sets the pending flag with the interrupt enable off and then turns the enable on; a design whose flag is not sticky, or whose gate is wrong, shows the wrong level on `irq`.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 2 * DATA_W;
  localparam int CTL_BIT = 2;

  localparam logic [ADDR_W-1:0] A_IEN  = 4'h2;
  localparam logic [ADDR_W-1:0] A_RLO  = 4'h3;
  localparam logic [ADDR_W-1:0] A_RHI  = 4'h4;
  localparam logic [ADDR_W-1:0] A_RUN  = 4'h9;

  typedef enum logic [1:0] {
    CKM_DUAL = 2'b00,
    CKM_SLOW = 2'b01,
    CKM_FAST = 2'b10,
    CKM_NONE = 2'b11
  } ckmode_e;

  // Next counter value on an accepted tick: wrap past zero reloads.
  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cur,
                                                  input logic [CNT_W-1:0] reload);
    logic [CNT_W-1:0] one;
    one = {{(CNT_W-1){1'b0}}, 1'b1};
    if (cur == '0) next_count = reload;
    else           next_count = cur - one;
  endfunction

  // Control register image: only the control bit is implemented.
  function automatic logic [DATA_W-1:0] ctl_image(input logic bitval);
    logic [DATA_W-1:0] v;
    v = '0;
    v[CTL_BIT] = bitval;
    ctl_image = v;
  endfunction
endpackage

// File: rtl/tmr16_regs.sv
module tmr16_regs
  import tmr16_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              run_en,
  output logic              int_en,
  output logic [CNT_W-1:0]  reload
);
  logic [DATA_W-1:0] rlo_q, rhi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_en <= 1'b0;
      int_en <= 1'b0;
      rlo_q  <= '0;
      rhi_q  <= '0;
    end else if (we) begin
      case (addr)
        A_IEN: int_en <= wdata[CTL_BIT];
        A_RUN: run_en <= wdata[CTL_BIT];
        A_RLO: rlo_q  <= wdata;
        A_RHI: rhi_q  <= wdata;
        default: ;
      endcase
    end
  end

  assign reload = {rhi_q, rlo_q};

  always_comb begin
    case (addr)
      A_IEN:   rdata = ctl_image(int_en);
      A_RUN:   rdata = ctl_image(run_en);
      default: rdata = '0;
    endcase
  end

  a_r7_run_write: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_RUN) |=> (run_en == $past(wdata[CTL_BIT])));
  a_r7_ien_write: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_IEN) |=> (int_en == $past(wdata[CTL_BIT])));
  a_r6_reload_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(reload));
endmodule

// File: rtl/tmr16_tick_sel.sv
module tmr16_tick_sel
  import tmr16_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       slow_tick,
  input  logic       fast_tick,
  output logic       tick
);
  always_comb begin
    case (ckmode_e'(mode))
      CKM_DUAL, CKM_SLOW: tick = slow_tick;
      CKM_FAST:           tick = fast_tick;
      default:            tick = 1'b0;
    endcase
  end

  always_comb begin
    if (mode == CKM_NONE)
      a_r9_none_silent: assert (!tick);
  end
endmodule

// File: rtl/tmr16_counter.sv
module tmr16_counter
  import tmr16_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run_en,
  input  logic [CNT_W-1:0] reload,
  input  logic             clr,
  output logic             pending,
  output logic             underflow
);
  logic [CNT_W-1:0] cnt_q;
  logic             step;
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  assign step      = tick & run_en;
  assign underflow = step & (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (step) cnt_q <= next_count(cnt_q, reload);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         pending <= 1'b0;
    else if (underflow) pending <= 1'b1;
    else if (clr)       pending <= 1'b0;
  end

  a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));
  a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> (cnt_q == $past(reload)) && pending);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt_q));
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !underflow) |=> !pending);
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !clr) |=> pending);
endmodule

// File: rtl/tmr16_top.sv
module tmr16_top
  import tmr16_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [1:0]        clk_mode,
  input  logic              slow_tick,
  input  logic              fast_tick,
  input  logic              irq_clear,
  output logic              irq
);
  logic             run_en, int_en, tick, pending, underflow;
  logic [CNT_W-1:0] reload;

  tmr16_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata),
    .run_en(run_en), .int_en(int_en), .reload(reload)
  );

  tmr16_tick_sel u_sel (
    .mode(clk_mode), .slow_tick(slow_tick), .fast_tick(fast_tick), .tick(tick)
  );

  tmr16_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run_en(run_en),
    .reload(reload), .clr(irq_clear), .pending(pending), .underflow(underflow)
  );

  assign irq = pending & int_en;

  a_r10_no_uf_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> !underflow);
  a_r8_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !int_en |-> !irq);
endmodule

// File: tb/tb_tmr16_top.sv
module tb_tmr16_top;
  logic       clk = 1'b0;
  logic       rst_n, bus_we, slow_tick, fast_tick, irq_clear;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [1:0] clk_mode;
  logic [7:0] bus_rdata;
  logic       irq;

  always #5 clk = ~clk;

  tmr16_top dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_mode(clk_mode),
    .slow_tick(slow_tick), .fast_tick(fast_tick), .irq_clear(irq_clear), .irq(irq)
  );

  typedef struct { string req; bit is_rd; logic [7:0] exp; } item_t;
  item_t q[$];
  int checks = 0, fails = 0;
  bit finished = 0;

  // reference model
  int   m_cnt = 0;
  int   m_pre = 0;
  bit   m_pend = 0, m_ie = 0, m_en = 0;

  // monitor: compares queued expectations away from the clock edge
  always @(negedge clk) begin
    item_t it;
    logic [7:0] act;
    while (q.size() > 0) begin
      it = q.pop_front();
      act = it.is_rd ? bus_rdata : {7'b0, irq};
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s: %s actual %0h expected %0h", it.req,
                 it.is_rd ? "rdata" : "irq", act, it.exp);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk) #1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk) #1; bus_we = 0;
    case (a)
      4'h2: m_ie = d[2];
      4'h9: m_en = d[2];
      4'h3: m_pre = (m_pre & 32'hFF00) | d;
      4'h4: m_pre = (m_pre & 32'h00FF) | (int'(d) << 8);
      default: ;
    endcase
  endtask

  task automatic rd_chk(input string req, input logic [3:0] a, input logic [7:0] e);
    @(posedge clk) #1; bus_addr = a;
    q.push_back('{req, 1'b1, e});
  endtask

  task automatic irq_chk(input string req);
    q.push_back('{req, 1'b0, {7'b0, m_pend & m_ie}});
  endtask

  task automatic irq_exp(input string req, input bit e);
    q.push_back('{req, 1'b0, {7'b0, e}});
  endtask

  // one tick pulse on the slow (fast=0) or fast (fast=1) input
  task automatic tick(input bit fast);
    bit sel;
    @(posedge clk) #1; slow_tick = !fast; fast_tick = fast;
    @(posedge clk) #1; slow_tick = 0; fast_tick = 0;
    sel = (clk_mode == 2'b10) ? fast : (clk_mode == 2'b11) ? 1'b0 : !fast;
    if (sel && m_en) begin
      if (m_cnt == 0) begin m_cnt = m_pre; m_pend = 1; end
      else m_cnt = m_cnt - 1;
    end
  endtask

  task automatic clr;
    @(posedge clk) #1; irq_clear = 1;
    @(posedge clk) #1; irq_clear = 0;
    m_pend = 0;
  endtask

  initial begin
    rst_n = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    clk_mode = 2'b00; slow_tick = 0; fast_tick = 0; irq_clear = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    irq_exp("R1", 0);
    rd_chk("R1", 4'h2, 8'h00);
    rd_chk("R1", 4'h9, 8'h00);

    // R6 reload registers are write-only
    wr(4'h3, 8'h03); wr(4'h4, 8'h00);
    rd_chk("R6", 4'h3, 8'h00);
    rd_chk("R6", 4'h4, 8'h00);

    // R7 control registers
    wr(4'h2, 8'hFF);
    rd_chk("R7", 4'h2, 8'h04);
    rd_chk("R7", 4'h7, 8'h00);
    wr(4'h9, 8'h04);
    rd_chk("R7", 4'h9, 8'h04);

    // R10 ticks on the unselected input do nothing (mode 00 uses slow)
    tick(1); irq_exp("R9", 0);

    // R5 first tick after enable interrupts immediately
    tick(0); irq_exp("R5", 1);
    clr; irq_exp("R8", 0);

    // R4 interval N+1 = 4 ticks; R2 no interrupt on intermediate ticks
    for (int i = 0; i < 3; i++) begin tick(0); irq_exp("R2", 0); end
    tick(0); irq_exp("R4", 1);
    clr;

    // R6 write reload mid-period: current period still 4 ticks
    tick(0); wr(4'h3, 8'h01);
    tick(0); irq_exp("R6", 0);
    tick(0); irq_exp("R6", 0);
    tick(0); irq_exp("R6", 1);
    clr;
    tick(0); irq_exp("R6", 0);
    tick(0); irq_exp("R6", 1);
    clr;

    // R9 fast-only mode: slow ignored, fast counts
    clk_mode = 2'b10;
    tick(0); tick(0); tick(0); irq_exp("R9", 0);
    tick(1); irq_exp("R9", 0);
    tick(1); irq_exp("R9", 1);
    clr;
    // R9 mode 11 selects nothing
    clk_mode = 2'b11;
    tick(0); tick(1); tick(0); tick(1); irq_exp("R9", 0);
    // R9 slow-only mode
    clk_mode = 2'b01;
    tick(1); irq_exp("R9", 0);
    tick(0); tick(0); irq_exp("R9", 1);

    // R8 simultaneous clear and underflow: set wins
    tick(0);
    @(posedge clk) #1; irq_clear = 1; slow_tick = 1;
    @(posedge clk) #1; irq_clear = 0; slow_tick = 0;
    m_cnt = m_pre; m_pend = 1;
    irq_exp("R8", 1);
    clr;

    // R8 gating: pending with enable off, then on
    wr(4'h2, 8'h00);
    tick(0); tick(0); irq_exp("R8", 0);
    wr(4'h2, 8'h04); irq_exp("R8", 1);
    clr;

    // R10 disabled: ticks hold the count
    wr(4'h9, 8'h00);
    for (int i = 0; i < 5; i++) tick(0);
    irq_exp("R10", 0);
    wr(4'h9, 8'h04);
    tick(0); irq_exp("R10", 0);
    tick(0); irq_exp("R10", 1);
    clr;

    // R4 high byte: reload 0x0102 -> 259 ticks between interrupts
    wr(4'h3, 8'h02); wr(4'h4, 8'h01);
    tick(0); tick(0); irq_exp("R4", 1); clr;
    for (int i = 0; i < 258; i++) tick(0);
    irq_exp("R4", 0);
    tick(0); irq_exp("R4", 1);
    // model cross-check of final state
    irq_chk("R3");

    repeat (3) @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule